// File: doc/BRIEF.md
# Key-Change Wakeup and Standby Controller

This block decides when a processor sleeps and when it comes back. Software puts the core to sleep by writing a fixed 16-bit key to the sleep register. The block then drops the CPU clock gate and the PLL enable, and holds both low until a wakeup condition appears. A wakeup condition is one of four things: a change on the 16-bit input port, a real-time-clock tick, a fast interrupt, or an enabled interrupt line.

Key wakeup works against a reference value. Each software read of the port data register stores the current synchronized port value as the reference. While key wakeup is enabled, any difference between the live port and the reference is a wakeup condition. The block also holds the CPU clock divider selection. Every wake puts the divider back to its default of divide-by-8, so the core restarts at a safe speed.

The pad logic, the oscillator and the PLL are outside this block. It only drives their enables.

Top module: `kwake_standby_ctrl`

## Requirements
- R1: After reset, `standby` is 0, `cpu_clk_en` and `pll_en` are 1, `div_sel` is 3 and `wake_evt` is 0.
- R2: In run, writing 16'h5555 to the sleep register with no wakeup condition present sets `standby` on the next clock edge and clears `cpu_clk_en` and `pll_en`.
- R3: A sleep-register write of any other value is ignored: the block stays in run.
- R4: `port_rd_data` shows the synchronized port value. A `port_rd` pulse stores that value as the key reference on the same clock edge.
- R5: With `key_wake_en` at 1, a synchronized port value that differs from the reference wakes the block from standby on the next edge. With `key_wake_en` at 0, port changes have no effect.
- R6: `rtc_tick` wakes the block only while `rtc_wake_en` is 1.
- R7: `fiq_req` always wakes the block. Bit n of `irq_req` wakes it only when bit n of `irq_en` is 1.
- R8: `div_sel` code k selects divide-by-2^k for k = 0..6, and the value is written through `div_wr`. A write of code 7 is ignored.
- R9: Every wake sets `div_sel` to 3 (divide-by-8), whatever was programmed before the sleep.
- R10: If a wakeup condition is already present on the cycle of a valid sleep write, the block stays in run. It still pulses `wake_evt` and resets `div_sel` to 3.
- R11: `wake_evt` is a one-cycle pulse, set on the edge that ends a standby or cancels a sleep.
- R12: Port pins pass through two flops before use. A pin change reaches `port_rd_data` two clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running control clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_pins | input | 16 | Asynchronous key port inputs |
| port_rd | input | 1 | Software read strobe of the port data register; captures the reference |
| port_rd_data | output | 16 | Synchronized port value |
| key_wake_en | input | 1 | Enables wakeup on port change |
| rtc_tick | input | 1 | Real-time-clock tick |
| rtc_wake_en | input | 1 | Enables wakeup on the RTC tick |
| fiq_req | input | 1 | Fast interrupt request; always a wakeup source |
| irq_req | input | 8 | Interrupt request lines |
| irq_en | input | 8 | Per-line interrupt wakeup enables |
| sleep_wr | input | 1 | Sleep register write strobe |
| sleep_wdata | input | 16 | Sleep register write data |
| div_wr | input | 1 | Divider selection write strobe |
| div_wdata | input | 3 | Divider code to write |
| standby | output | 1 | High while in standby |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| pll_en | output | 1 | PLL / system clock enable |
| div_sel | output | 3 | CPU clock divider code (divide by 2^code) |
| wake_evt | output | 1 | One-cycle pulse when a wake takes effect |

## Verification
The bench goes after five corner cases:

- **Synchronizer latency.** It checks the port value one edge and two edges after a pin change. A design with one flop, or three, shows the new value too early or too late.
- **Wakeup enables.** It changes the port with key wakeup disabled, and gives ticks and interrupt lines while their enables are low. A design that ignores an enable leaves standby when it should not.
- **Sleep key and divider code.** It writes a near-miss sleep key and the illegal divider code 7. A decoder that is too loose falls asleep or loads a bad divider.
- **Sleep write during a pending wakeup.** It raises an interrupt on the same cycle as the sleep write. A design that does not handle this gates the clock and then depends on a second event to recover.
- **Divider on wake.** It checks that every wake returns the divider to divide-by-8. A design that keeps the pre-sleep code restarts the core at full speed.

// File: rtl/kwake_pkg.sv
// Package: shared constants and types for the key-change wakeup controller.
// Assumes a 3-bit divider code where code k means divide by 2^k.
package kwake_pkg;
    localparam int          DIV_W       = 3;
    localparam logic [2:0]  DIV_DEFAULT = 3'd3;   // divide-by-8
    localparam logic [2:0]  DIV_MAX     = 3'd6;   // divide-by-64

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_STBY = 1'b1
    } pwr_state_t;
endpackage

// File: rtl/kwake_sync.sv
// Module: two-flop synchronizer for a bus of independent asynchronous pins.
// Assumes each bit is sampled on its own (no multi-bit coherence is needed).
module kwake_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    // Move the pins through two flop stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= async_in;
            stage2 <= stage1;
        end
    end

    assign sync_out = stage2;
endmodule

// File: rtl/kwake_change_det.sv
// Module: keeps the wakeup reference and flags a difference from it.
// Assumes rd_stb is a one-cycle software read strobe of the port data register.
module kwake_change_det #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] live,
    input  logic         rd_stb,
    input  logic         enable,
    output logic         changed
);
    logic [W-1:0] snap;

    // Store the live value as the new reference on every read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap <= '0;
        end else if (rd_stb) begin
            snap <= live;
        end
    end

    // The wakeup condition is any bit that differs while enabled.
    always_comb begin
        changed = enable && (live != snap);
    end

    // R4
    snap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> (snap == $past(live)));

    // R4
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(snap));
endmodule

// File: rtl/kwake_div_sel.sv
// Module: CPU clock divider selection register.
// Assumes writes are accepted only while the core runs. A wake has priority
// over a write and restores the default code.
module kwake_div_sel
    import kwake_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             wr,
    input  logic [DIV_W-1:0] wdata,
    input  logic             wake_go,
    output logic [DIV_W-1:0] sel
);
    logic code_ok;

    // A code is legal only up to the divide-by-64 setting.
    always_comb begin
        code_ok = (wdata <= DIV_MAX);
    end

    // Update the divider code: the wake reset comes first, then legal writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel <= DIV_DEFAULT;
        end else if (wake_go) begin
            sel <= DIV_DEFAULT;
        end else if (wr && run && code_ok) begin
            sel <= wdata;
        end
    end

    // R9
    div_wake_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_go |=> (sel == DIV_DEFAULT));

    // R8
    div_bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wdata == 3'd7 && !wake_go) |=> $stable(sel));

    // R8
    div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel <= DIV_MAX);
endmodule

// File: rtl/kwake_fsm.sv
// Module: run/standby state machine with the wake pulse.
// Assumes wake_any is the combined, already-enabled wakeup condition.
module kwake_fsm
    import kwake_pkg::*;
#(
    parameter int          KEY_W     = 16,
    parameter logic [15:0] SLEEP_KEY = 16'h5555
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_wr,
    input  logic [KEY_W-1:0] sleep_wdata,
    input  logic             wake_any,
    output pwr_state_t       state,
    output logic             wake_go,
    output logic             wake_evt
);
    logic       sleep_ok;
    pwr_state_t state_nx;

    // Decode a valid sleep request and the next state.
    always_comb begin
        sleep_ok = sleep_wr && (sleep_wdata == KEY_W'(SLEEP_KEY));
        state_nx = state;
        wake_go  = 1'b0;
        if (state == ST_RUN) begin
            if (sleep_ok && wake_any) begin
                wake_go = 1'b1;
            end else if (sleep_ok) begin
                state_nx = ST_STBY;
            end
        end else if (wake_any) begin
            wake_go  = 1'b1;
            state_nx = ST_RUN;
        end
    end

    // Register the state and the one-cycle wake pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_RUN;
            wake_evt <= 1'b0;
        end else begin
            state    <= state_nx;
            wake_evt <= wake_go;
        end
    end

    // R2
    sleep_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && sleep_wr && sleep_wdata == KEY_W'(SLEEP_KEY) && !wake_any)
            |=> (state == ST_STBY && !wake_evt));

    // R3
    sleep_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !(sleep_wr && sleep_wdata == KEY_W'(SLEEP_KEY)))
            |=> (state == ST_RUN));

    // R10
    sleep_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && sleep_wr && sleep_wdata == KEY_W'(SLEEP_KEY) && wake_any)
            |=> (state == ST_RUN && wake_evt));

    // R11
    stby_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STBY && wake_any) |=> (state == ST_RUN && wake_evt));

    // R11
    stby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STBY && !wake_any) |=> (state == ST_STBY && !wake_evt));
endmodule

// File: rtl/kwake_standby_ctrl.sv
// Module: top of the key-change wakeup and standby controller.
// Assumes clk keeps running in standby; only the CPU clock gate and
// the PLL enable are dropped.
module kwake_standby_ctrl
    import kwake_pkg::*;
#(
    parameter int          PORT_W    = 16,
    parameter int          IRQ_N     = 8,
    parameter int          KEY_W     = 16,
    parameter logic [15:0] SLEEP_KEY = 16'h5555
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] port_pins,
    input  logic              port_rd,
    output logic [PORT_W-1:0] port_rd_data,
    input  logic              key_wake_en,
    input  logic              rtc_tick,
    input  logic              rtc_wake_en,
    input  logic              fiq_req,
    input  logic [IRQ_N-1:0]  irq_req,
    input  logic [IRQ_N-1:0]  irq_en,
    input  logic              sleep_wr,
    input  logic [KEY_W-1:0]  sleep_wdata,
    input  logic              div_wr,
    input  logic [DIV_W-1:0]  div_wdata,
    output logic              standby,
    output logic              cpu_clk_en,
    output logic              pll_en,
    output logic [DIV_W-1:0]  div_sel,
    output logic              wake_evt
);
    logic [PORT_W-1:0] port_sync;
    logic              key_hit;
    logic              wake_any;
    logic              wake_go;
    pwr_state_t        state;

    kwake_sync #(.W(PORT_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (port_pins),
        .sync_out (port_sync)
    );

    kwake_change_det #(.W(PORT_W)) u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .live    (port_sync),
        .rd_stb  (port_rd),
        .enable  (key_wake_en),
        .changed (key_hit)
    );

    // Combine every enabled wakeup source.
    always_comb begin
        wake_any = key_hit
                 | (rtc_wake_en & rtc_tick)
                 | fiq_req
                 | (|(irq_req & irq_en));
    end

    kwake_fsm #(.KEY_W(KEY_W), .SLEEP_KEY(SLEEP_KEY)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_wr    (sleep_wr),
        .sleep_wdata (sleep_wdata),
        .wake_any    (wake_any),
        .state       (state),
        .wake_go     (wake_go),
        .wake_evt    (wake_evt)
    );

    kwake_div_sel u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state == ST_RUN),
        .wr      (div_wr),
        .wdata   (div_wdata),
        .wake_go (wake_go),
        .sel     (div_sel)
    );

    // Drive the power outputs from the registered state.
    always_comb begin
        standby      = (state == ST_STBY);
        cpu_clk_en   = (state == ST_RUN);
        pll_en       = (state == ST_RUN);
        port_rd_data = port_sync;
    end

    // R2
    gate_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en == pll_en) && (cpu_clk_en != standby));

    // R7
    fiq_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (standby && fiq_req) |=> !standby);

    // R5
    key_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (standby && !key_wake_en && !rtc_tick && !fiq_req && !(|irq_req)) |=> standby);
endmodule

// File: tb/sim_kwake_standby_ctrl.sv
module sim_kwake_standby_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] port_pins = '0;
    logic        port_rd = 1'b0;
    logic [15:0] port_rd_data;
    logic        key_wake_en = 1'b0;
    logic        rtc_tick = 1'b0;
    logic        rtc_wake_en = 1'b0;
    logic        fiq_req = 1'b0;
    logic [7:0]  irq_req = '0;
    logic [7:0]  irq_en = '0;
    logic        sleep_wr = 1'b0;
    logic [15:0] sleep_wdata = '0;
    logic        div_wr = 1'b0;
    logic [2:0]  div_wdata = '0;
    logic        standby, cpu_clk_en, pll_en, wake_evt;
    logic [2:0]  div_sel;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        string       tag;
        logic        sb;
        logic [2:0]  dv;
        logic        ev;
        logic [15:0] rd;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;   // 125 MHz

    kwake_standby_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .port_pins(port_pins), .port_rd(port_rd),
        .port_rd_data(port_rd_data), .key_wake_en(key_wake_en),
        .rtc_tick(rtc_tick), .rtc_wake_en(rtc_wake_en), .fiq_req(fiq_req),
        .irq_req(irq_req), .irq_en(irq_en), .sleep_wr(sleep_wr),
        .sleep_wdata(sleep_wdata), .div_wr(div_wr), .div_wdata(div_wdata),
        .standby(standby), .cpu_clk_en(cpu_clk_en), .pll_en(pll_en),
        .div_sel(div_sel), .wake_evt(wake_evt)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver side: push the expected outputs for this negedge.
    task automatic expect_out(input string tag, input logic sb, input logic [2:0] dv,
                              input logic ev, input logic [15:0] rd);
        exp_t e;
        e.tag = tag; e.sb = sb; e.dv = dv; e.ev = ev; e.rd = rd;
        q.push_back(e);
    endtask

    // Monitor: pop expected items and compare them just after each negedge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (standby !== e.sb || cpu_clk_en !== !e.sb || pll_en !== !e.sb ||
                    div_sel !== e.dv || wake_evt !== e.ev || port_rd_data !== e.rd) begin
                    errors++;
                    $display("FAIL %s: got sb=%b clk=%b pll=%b div=%0d evt=%b rd=%h exp sb=%b clk=%b pll=%b div=%0d evt=%b rd=%h",
                             e.tag, standby, cpu_clk_en, pll_en, div_sel, wake_evt, port_rd_data,
                             e.sb, !e.sb, !e.sb, e.dv, e.ev, e.rd);
                end
            end
        end
    end

    task automatic do_sleep(input logic [15:0] val);
        sleep_wr = 1'b1; sleep_wdata = val; tick(1);
        sleep_wr = 1'b0; sleep_wdata = '0;
    endtask

    task automatic do_div(input logic [2:0] c);
        div_wr = 1'b1; div_wdata = c; tick(1);
        div_wr = 1'b0;
    endtask

    task automatic do_read();
        port_rd = 1'b1; tick(1); port_rd = 1'b0;
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hung run exp finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        expect_out("R1 reset state", 0, 3, 0, 16'h0000);

        // R12: two-flop latency on the port.
        port_pins = 16'hA5A5;
        tick(1);
        expect_out("R12 one edge later", 0, 3, 0, 16'h0000);
        tick(1);
        expect_out("R12 two edges later", 0, 3, 0, 16'hA5A5);

        // R4: capture reference.
        do_read();
        expect_out("R4 read keeps value", 0, 3, 0, 16'hA5A5);

        // R8: divider codes.
        do_div(3'd0);
        expect_out("R8 code 0", 0, 0, 0, 16'hA5A5);
        do_div(3'd6);
        expect_out("R8 code 6", 0, 6, 0, 16'hA5A5);
        do_div(3'd7);
        expect_out("R8 code 7 ignored", 0, 6, 0, 16'hA5A5);

        // R3: wrong key ignored.
        key_wake_en = 1'b1;
        do_sleep(16'h5554);
        expect_out("R3 near-miss key", 0, 6, 0, 16'hA5A5);
        do_sleep(16'hAAAA);
        expect_out("R3 other key", 0, 6, 0, 16'hA5A5);

        // R2: valid key enters standby.
        do_sleep(16'h5555);
        expect_out("R2 standby entered", 1, 6, 0, 16'hA5A5);
        tick(3);
        expect_out("R2 standby held", 1, 6, 0, 16'hA5A5);

        // R5: key change wakes, R9 divider reset, R11 pulse.
        port_pins = 16'hA5A4;
        tick(2);
        expect_out("R5 not yet synchronized", 1, 6, 0, 16'hA5A4);
        tick(1);
        expect_out("R5 R9 R11 key wake", 0, 3, 1, 16'hA5A4);
        tick(1);
        expect_out("R11 pulse ends", 0, 3, 0, 16'hA5A4);

        // R5: disabled key wake has no effect.
        do_read();
        key_wake_en = 1'b0;
        do_div(3'd5);
        do_sleep(16'h5555);
        port_pins = 16'h0000;
        tick(4);
        expect_out("R5 key wake disabled", 1, 5, 0, 16'h0000);

        // R6: RTC gated by its enable.
        rtc_tick = 1'b1;
        tick(2);
        expect_out("R6 rtc disabled", 1, 5, 0, 16'h0000);
        rtc_wake_en = 1'b1;
        tick(1);
        rtc_tick = 1'b0; rtc_wake_en = 1'b0;
        expect_out("R6 R9 rtc wake", 0, 3, 1, 16'h0000);

        // R7: masked and enabled IRQ lines.
        do_read();
        key_wake_en = 1'b1;
        do_sleep(16'h5555);
        irq_req = 8'h04; irq_en = 8'h01;
        tick(2);
        expect_out("R7 irq masked", 1, 3, 0, 16'h0000);
        irq_en = 8'h04;
        tick(1);
        irq_req = '0; irq_en = '0;
        expect_out("R7 irq enabled wake", 0, 3, 1, 16'h0000);

        // R7: fast interrupt always wakes.
        do_div(3'd2);
        do_sleep(16'h5555);
        expect_out("R7 standby before fiq", 1, 2, 0, 16'h0000);
        fiq_req = 1'b1;
        tick(1);
        fiq_req = 1'b0;
        expect_out("R7 R9 fiq wake", 0, 3, 1, 16'h0000);

        // R10: wake already present at the sleep write.
        do_div(3'd1);
        fiq_req = 1'b1;
        do_sleep(16'h5555);
        fiq_req = 1'b0;
        expect_out("R10 sleep cancelled", 0, 3, 1, 16'h0000);
        tick(1);
        expect_out("R10 R11 still running", 0, 3, 0, 16'h0000);

        tick(2);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule